// File: doc/BRIEF.md
# USART Baud and Clock Generator

This block turns the system clock into the bit-rate timing that a USART transmitter and receiver need. A down-counter reloads from a 12-bit divisor and emits one base tick every divisor + 1 system cycles. A post-divider then turns that tick into single-cycle transmit and receive clock enables. The enables live in the system clock domain; they are not derived clocks.

Three operating modes are supported. In asynchronous normal speed, the receive enable is the raw base tick and the transmit enable fires on every 16th tick. In asynchronous double speed, the transmit enable fires on every 8th tick. In synchronous operation, the serial clock pin direction picks the role:

- As master, the block toggles its external clock output on every base tick. This divides the tick by two. It issues the transmit enable on the launch edge of that clock and the receive enable on the sample edge.
- As slave, the counter is bypassed. The external clock input passes through a two-flop synchronizer and an edge detector. The transmit enable then follows the detected launch edge and the receive enable follows the sample edge.

In both synchronous roles, a polarity input chooses which edge launches and which samples.

Software writes the divisor's low byte and pulses a write strobe at the same time. That restarts the count period at once.

Top module: `usart_clkgen`

## Requirements
- R1: While reset is low, the counter loads the divisor value and tx_en_o, rx_en_o and ext_clk_o are all 0 on the cycle after each reset edge.
- R2: In both asynchronous modes, rx_en_o pulses for one cycle every D+1 cycles, where D is the divisor. The first pulse follows the (D+1)th clock edge after reset release. A divisor of 0 gives a pulse on every cycle.
- R3: When div_lo_wr_i is high at a clock edge, the counter reloads from div_i at that edge. Any base tick in that cycle is suppressed, so the next rx_en_o pulse (asynchronous mode) appears exactly D_new+1 edges after the strobe edge.
- R4: In asynchronous normal mode (sync_mode_i=0, dbl_speed_i=0), tx_en_o pulses together with every 16th rx_en_o pulse after reset.
- R5: In asynchronous double-speed mode (sync_mode_i=0, dbl_speed_i=1), tx_en_o pulses together with every 8th rx_en_o pulse after reset.
- R6: In synchronous master mode (sync_mode_i=1, clk_pin_out_i=1), ext_clk_o starts at 0 after reset and toggles on every base tick, so its period is 2*(D+1) cycles.
- R7: In master mode with polarity_i=0, tx_en_o is high exactly in the cycles where ext_clk_o has just risen and rx_en_o exactly where it has just fallen; polarity_i=1 swaps the two.
- R8: In synchronous slave mode (sync_mode_i=1, clk_pin_out_i=0), a launch edge on ext_clk_i makes tx_en_o high for one cycle after the third clock edge following the change, and a sample edge does the same for rx_en_o. The launch edge is rising for polarity_i=0 and falling for polarity_i=1. ext_clk_o stays 0 and the divisor has no effect.
- R9: In both asynchronous modes ext_clk_o stays 0.
- R10: In synchronous modes tx_en_o and rx_en_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_i | input | 12 | Divisor register value |
| div_lo_wr_i | input | 1 | Strobe: low divisor byte written this cycle |
| sync_mode_i | input | 1 | 1 selects synchronous operation |
| dbl_speed_i | input | 1 | 1 selects double speed in asynchronous operation |
| clk_pin_out_i | input | 1 | Serial clock pin direction, 1 = output (master) |
| polarity_i | input | 1 | Synchronous clock polarity (0: launch on rising edge) |
| ext_clk_i | input | 1 | Serial clock pin input, asynchronous |
| tx_en_o | output | 1 | Transmit clock enable, one cycle wide |
| rx_en_o | output | 1 | Receive clock enable, one cycle wide |
| ext_clk_o | output | 1 | Serial clock pin output in master mode |

## Verification
The assertions assume that the mode controls (sync_mode_i, dbl_speed_i, clk_pin_out_i, polarity_i) stay put for a few cycles before the checked behaviour. Outputs registered just after a mode change may mix the old and new modes, so mode-dependent properties are gated by a stability counter. The stimulus only changes the mode while reset is held and never switches it during a run. In slave mode, ext_clk_i is held for several system cycles between toggles, so the synchronizer sees every level. The bench compares every output on every cycle against tick numbers it computes from the divisor.

// File: rtl/usart_clkgen_pkg.sv
// Shared types for the USART baud and clock generator.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package usart_clkgen_pkg;

    // Operating mode derived jointly from the three mode controls.
    typedef enum logic [1:0] {
        OPM_ASYNC_X16   = 2'd0,
        OPM_ASYNC_X8    = 2'd1,
        OPM_SYNC_MASTER = 2'd2,
        OPM_SYNC_SLAVE  = 2'd3
    } opm_e;

    // Map mode, double-speed and pin direction onto one operating mode.
    function automatic opm_e decode_opm(input logic sync_mode,
                                        input logic dbl_speed,
                                        input logic pin_out);
        opm_e m;
        if (sync_mode) begin
            m = pin_out ? OPM_SYNC_MASTER : OPM_SYNC_SLAVE;
        end else begin
            m = dbl_speed ? OPM_ASYNC_X8 : OPM_ASYNC_X16;
        end
        return m;
    endfunction

endpackage

// File: rtl/usart_baud_counter.sv
// Programmable down-counter producing the base tick.
// Loads div_i at reset, on reaching zero, and on a reload strobe.
// A tick is issued in each cycle in which the count is zero,
// unless a reload happens in that same cycle.
// Assumes: div_i is stable whenever reload_i is low.
module usart_baud_counter #(
    parameter int unsigned DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    input  logic             reload_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_q;
    logic             at_zero;

    assign at_zero = (cnt_q == '0);
    assign tick_o  = at_zero && !reload_i;

    // Count down; reload on zero, on a divisor write, or in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= div_i;
        end else if (reload_i || at_zero) begin
            cnt_q <= div_i;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/usart_post_div.sv
// Mode-dependent post-divider for the internally generated clock.
// Asynchronous modes: a phase counter counts base ticks, and the
// transmit event fires on the full (x16) or half (x8) wrap.
// Synchronous master: a clock flop toggles on each tick; launch and
// sample events are chosen by polarity.
// Slave mode yields no events here.
// Assumes: tick_i is a single-cycle pulse in the clk domain.
module usart_post_div
    import usart_clkgen_pkg::*;
#(
    parameter int unsigned PH_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  opm_e opm_i,
    input  logic pol_i,
    output logic tx_evt_o,
    output logic rx_evt_o,
    output logic xck_o
);

    localparam int unsigned HALF_W = PH_W - 1;

    logic [PH_W-1:0] ph_q;
    logic            xck_q;
    logic            full_wrap;
    logic            half_wrap;
    logic            rise_evt;
    logic            fall_evt;
    logic            launch_evt;
    logic            sample_evt;
    logic            is_async;

    assign is_async  = (opm_i == OPM_ASYNC_X16) || (opm_i == OPM_ASYNC_X8);
    assign full_wrap = &ph_q;
    assign half_wrap = &ph_q[HALF_W-1:0];

    // Advance the phase counter on base ticks in asynchronous modes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else if (is_async && tick_i) begin
            ph_q <= ph_q + 1'b1;
        end
    end

    // Toggle the generated serial clock in master mode, idle low otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xck_q <= 1'b0;
        end else if (opm_i != OPM_SYNC_MASTER) begin
            xck_q <= 1'b0;
        end else if (tick_i) begin
            xck_q <= !xck_q;
        end
    end

    assign rise_evt   = tick_i && !xck_q;
    assign fall_evt   = tick_i &&  xck_q;
    assign launch_evt = pol_i ? fall_evt : rise_evt;
    assign sample_evt = pol_i ? rise_evt : fall_evt;

    // Select transmit and receive events for the active mode.
    always_comb begin
        tx_evt_o = 1'b0;
        rx_evt_o = 1'b0;
        case (opm_i)
            OPM_ASYNC_X16: begin
                tx_evt_o = tick_i && full_wrap;
                rx_evt_o = tick_i;
            end
            OPM_ASYNC_X8: begin
                tx_evt_o = tick_i && half_wrap;
                rx_evt_o = tick_i;
            end
            OPM_SYNC_MASTER: begin
                tx_evt_o = launch_evt;
                rx_evt_o = sample_evt;
            end
            default: begin
                tx_evt_o = 1'b0;
                rx_evt_o = 1'b0;
            end
        endcase
    end

    assign xck_o = xck_q;

endmodule

// File: rtl/usart_xck_sync.sv
// Synchronizer and edge detector for the external serial clock input.
// STAGES flops resynchronize the pin, and one more flop holds the
// previous synchronized level for edge detection.
// Assumes: the pin holds each level for at least two clk cycles.
module usart_xck_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic pol_i,
    output logic launch_o,
    output logic sample_o
);

    logic [STAGES:0] sh_q;
    logic            lvl;
    logic            lvl_prev;
    logic            rise;
    logic            fall;

    // Shift the pin level through the synchronizer and history flops.
    for (genvar g = 0; g <= STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) sh_q[g] <= 1'b0;
                else        sh_q[g] <= pin_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) sh_q[g] <= 1'b0;
                else        sh_q[g] <= sh_q[g-1];
            end
        end
    end

    assign lvl      = sh_q[STAGES-1];
    assign lvl_prev = sh_q[STAGES];
    assign rise     = lvl && !lvl_prev;
    assign fall     = !lvl && lvl_prev;
    assign launch_o = pol_i ? fall : rise;
    assign sample_o = pol_i ? rise : fall;

endmodule

// File: rtl/usart_clkgen.sv
// USART baud and clock generator top level.
// Decodes the operating mode, runs the baud counter and post-divider,
// handles the external clock in slave mode, and registers the
// transmit and receive enables.
// Assumes: mode controls change only while the USART is idle.
module usart_clkgen
    import usart_clkgen_pkg::*;
#(
    parameter int unsigned DIV_W       = 12,
    parameter int unsigned PH_W        = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    input  logic             div_lo_wr_i,
    input  logic             sync_mode_i,
    input  logic             dbl_speed_i,
    input  logic             clk_pin_out_i,
    input  logic             polarity_i,
    input  logic             ext_clk_i,
    output logic             tx_en_o,
    output logic             rx_en_o,
    output logic             ext_clk_o
);

    opm_e opm;
    logic base_tick;
    logic pd_tx;
    logic pd_rx;
    logic ex_launch;
    logic ex_sample;
    logic tx_nxt;
    logic rx_nxt;

    assign opm = decode_opm(sync_mode_i, dbl_speed_i, clk_pin_out_i);

    usart_baud_counter #(.DIV_W(DIV_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_i    (div_i),
        .reload_i (div_lo_wr_i),
        .tick_o   (base_tick)
    );

    usart_post_div #(.PH_W(PH_W)) u_pdiv (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (base_tick),
        .opm_i    (opm),
        .pol_i    (polarity_i),
        .tx_evt_o (pd_tx),
        .rx_evt_o (pd_rx),
        .xck_o    (ext_clk_o)
    );

    usart_xck_sync #(.STAGES(SYNC_STAGES)) u_xsync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_i    (ext_clk_i),
        .pol_i    (polarity_i),
        .launch_o (ex_launch),
        .sample_o (ex_sample)
    );

    // Pick the enable source: the external edges in slave mode, else the internal ones.
    always_comb begin
        if (opm == OPM_SYNC_SLAVE) begin
            tx_nxt = ex_launch;
            rx_nxt = ex_sample;
        end else begin
            tx_nxt = pd_tx;
            rx_nxt = pd_rx;
        end
    end

    // Register the enables so they are glitch-free single-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en_o <= 1'b0;
            rx_en_o <= 1'b0;
        end else begin
            tx_en_o <= tx_nxt;
            rx_en_o <= rx_nxt;
        end
    end

endmodule

// File: rtl/usart_clkgen_chk.sv
// Assertion checker for usart_clkgen, attached by bind.
// Mode-dependent properties are gated until the mode controls have
// been stable for a few cycles.
module usart_clkgen_chk (
    input logic clk,
    input logic rst_n,
    input logic div_lo_wr_i,
    input logic sync_mode_i,
    input logic dbl_speed_i,
    input logic clk_pin_out_i,
    input logic polarity_i,
    input logic tx_en_o,
    input logic rx_en_o,
    input logic ext_clk_o
);

    logic [3:0] cfg;
    logic [3:0] cfg_q;
    logic [1:0] calm_q;
    logic       prev_ext_q;
    logic       settled;

    assign cfg     = {sync_mode_i, dbl_speed_i, clk_pin_out_i, polarity_i};
    assign settled = (cfg == cfg_q) && (calm_q >= 2'd1);

    // Count cycles since the last change of the mode controls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= cfg;
            calm_q <= '0;
        end else begin
            cfg_q <= cfg;
            if (cfg != cfg_q)       calm_q <= '0;
            else if (calm_q != 2'd3) calm_q <= calm_q + 1'b1;
        end
    end

    // Remember the previous serial clock output level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_ext_q <= 1'b0;
        else        prev_ext_q <= ext_clk_o;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!tx_en_o && !rx_en_o && !ext_clk_o));

    assert_reload_mutes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && !sync_mode_i && div_lo_wr_i) |=> !rx_en_o);

    assert_tx_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && !sync_mode_i && tx_en_o) |-> rx_en_o);

    assert_launch_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && sync_mode_i && clk_pin_out_i && tx_en_o)
        |-> ((ext_clk_o != prev_ext_q) && (ext_clk_o == !polarity_i)));

    assert_sample_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && sync_mode_i && clk_pin_out_i && rx_en_o)
        |-> ((ext_clk_o != prev_ext_q) && (ext_clk_o == polarity_i)));

    assert_slave_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && sync_mode_i && !clk_pin_out_i) |-> !ext_clk_o);

    assert_async_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && !sync_mode_i) |-> !ext_clk_o);

    assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && sync_mode_i) |-> !(tx_en_o && rx_en_o));

endmodule

bind usart_clkgen usart_clkgen_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .div_lo_wr_i   (div_lo_wr_i),
    .sync_mode_i   (sync_mode_i),
    .dbl_speed_i   (dbl_speed_i),
    .clk_pin_out_i (clk_pin_out_i),
    .polarity_i    (polarity_i),
    .tx_en_o       (tx_en_o),
    .rx_en_o       (rx_en_o),
    .ext_clk_o     (ext_clk_o)
);

// File: tb/tb_usart_clkgen.sv
// Self-checking bench: per-cycle sweeps of divisor and mode, expected
// values from the tick number computed arithmetically.
module tb_usart_clkgen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] div_i = 12'd0;
    logic        div_lo_wr_i = 1'b0;
    logic        sync_mode_i = 1'b0;
    logic        dbl_speed_i = 1'b0;
    logic        clk_pin_out_i = 1'b0;
    logic        polarity_i = 1'b0;
    logic        ext_clk_i = 1'b0;
    logic        tx_en_o;
    logic        rx_en_o;
    logic        ext_clk_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    usart_clkgen dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .div_i         (div_i),
        .div_lo_wr_i   (div_lo_wr_i),
        .sync_mode_i   (sync_mode_i),
        .dbl_speed_i   (dbl_speed_i),
        .clk_pin_out_i (clk_pin_out_i),
        .polarity_i    (polarity_i),
        .ext_clk_i     (ext_clk_i),
        .tx_en_o       (tx_en_o),
        .rx_en_o       (rx_en_o),
        .ext_clk_o     (ext_clk_o)
    );

    // Record one aggregated check.
    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Hold reset with a configuration, check the reset state (R1), release.
    task automatic do_reset(input int d, input bit sm, input bit dbl,
                            input bit po, input bit pol);
        @(negedge clk);
        rst_n = 1'b0; div_i = d[11:0]; div_lo_wr_i = 1'b0;
        sync_mode_i = sm; dbl_speed_i = dbl; clk_pin_out_i = po;
        polarity_i = pol; ext_clk_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(!tx_en_o && !rx_en_o && !ext_clk_o, "R1", "outputs in reset",
              {tx_en_o, rx_en_o, ext_clk_o}, 0);
        rst_n = 1'b1;
    endtask

    // Run one internal-clock configuration and compare all outputs every cycle.
    task automatic run_cfg(input int d, input bit sm, input bit dbl,
                           input bit pol, input int ticks,
                           input string rtag, input string ttag, input string xtag);
        int n = (d + 1) * ticks;
        int bad_rx = 0, bad_tx = 0, bad_x = 0;
        int frx = 0, ftx = 0, fx = 0, erx = 0, etx = 0, ex = 0;
        do_reset(d, sm, dbl, 1'b1, pol);
        for (int e = 1; e <= n; e++) begin
            int t = (e % (d + 1) == 0) ? e / (d + 1) : 0;
            int so_far = e / (d + 1);
            bit xrx, xtx, xx;
            if (!sm) begin
                xrx = (t > 0);
                xtx = (t > 0) && ((t % (dbl ? 8 : 16)) == 0);
                xx  = 1'b0;
            end else begin
                bit rise = (t > 0) && (t % 2 == 1);
                bit fall = (t > 0) && (t % 2 == 0);
                xtx = pol ? fall : rise;
                xrx = pol ? rise : fall;
                xx  = (so_far % 2) == 1;
            end
            @(negedge clk);
            if (rx_en_o != xrx) begin if (bad_rx == 0) begin frx = rx_en_o; erx = xrx; end bad_rx++; end
            if (tx_en_o != xtx) begin if (bad_tx == 0) begin ftx = tx_en_o; etx = xtx; end bad_tx++; end
            if (ext_clk_o != xx) begin if (bad_x == 0) begin fx = ext_clk_o; ex = xx; end bad_x++; end
        end
        check(bad_rx == 0, rtag, $sformatf("rx_en d=%0d sm=%0d dbl=%0d pol=%0d", d, sm, dbl, pol), frx, erx);
        check(bad_tx == 0, ttag, $sformatf("tx_en d=%0d sm=%0d dbl=%0d pol=%0d", d, sm, dbl, pol), ftx, etx);
        check(bad_x == 0, xtag, $sformatf("ext_clk d=%0d sm=%0d", d, sm), fx, ex);
    endtask

    // R3: reloads on the low-byte write strobe restart the period.
    task automatic run_reload();
        int bad = 0, fa = 0, fe = 0;
        do_reset(4, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int e = 1; e <= 18; e++) begin
            bit xrx = (e == 12) || (e == 18);
            @(negedge clk);
            if (rx_en_o != xrx) begin if (bad == 0) begin fa = rx_en_o; fe = xrx; end bad++; end
            div_lo_wr_i = 1'b0;
            if (e == 4)  begin div_i = 12'd6; div_lo_wr_i = 1'b1; end
            if (e == 14) begin div_i = 12'd2; div_lo_wr_i = 1'b1; end
        end
        check(bad == 0, "R3", "rx_en after divisor writes", fa, fe);
    endtask

    // R8/R10: slave mode follows the synchronized external clock.
    task automatic run_slave(input bit pol);
        int bad_tx = 0, bad_rx = 0, bad_x = 0, both = 0;
        do_reset(0, 1'b1, 1'b0, 1'b0, pol);
        for (int k = 0; k < 20; k++) begin
            bit new_lvl = ~ext_clk_i;
            bit launch = pol ? !new_lvl : new_lvl;
            ext_clk_i = new_lvl;
            for (int c = 1; c <= 5; c++) begin
                bit xtx = (c == 3) && launch;
                bit xrx = (c == 3) && !launch;
                @(negedge clk);
                if (tx_en_o != xtx) bad_tx++;
                if (rx_en_o != xrx) bad_rx++;
                if (ext_clk_o) bad_x++;
                if (tx_en_o && rx_en_o) both++;
            end
        end
        check(bad_tx == 0, "R8", $sformatf("slave tx_en mismatches pol=%0d", pol), bad_tx, 0);
        check(bad_rx == 0, "R8", $sformatf("slave rx_en mismatches pol=%0d", pol), bad_rx, 0);
        check(bad_x == 0, "R8", "slave ext_clk_o high cycles", bad_x, 0);
        check(both == 0, "R10", "slave overlapping enables", both, 0);
    endtask

    initial begin
        int dl [5] = '{0, 1, 2, 5, 9};
        foreach (dl[i]) begin
            run_cfg(dl[i], 1'b0, 1'b0, 1'b0, 48, "R2", "R4", "R9");
            run_cfg(dl[i], 1'b0, 1'b1, 1'b0, 40, "R2", "R5", "R9");
            run_cfg(dl[i], 1'b1, 1'b0, 1'b0, 20, "R7", "R7", "R6");
            run_cfg(dl[i], 1'b1, 1'b0, 1'b1, 20, "R7", "R7", "R6");
        end
        run_cfg(1000, 1'b0, 1'b0, 1'b0, 17, "R2", "R4", "R9");
        run_cfg(300, 1'b1, 1'b0, 1'b0, 6, "R10", "R7", "R6");
        run_reload();
        run_slave(1'b0);
        run_slave(1'b1);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule